// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block turns a 32-bit virtual address into a 32-bit physical address. It walks a two-level table of short-format descriptors held in memory. A request is accepted together with a 3-bit split value and two table base words. The split value chooses which base serves the address and how much of that base is used for indexing. The walker then reads one or two descriptors through a single-outstanding memory read port. It resolves one of four mapping sizes: 1 MiB sections, 16 MiB supersections, 64 KiB large pages and 4 KiB small pages.

Each walk ends with a one-cycle done pulse that carries the physical address and a fault flag. Only one walk runs at a time. Requests that arrive while a walk is in progress are dropped. The split value, the base words and the virtual address are captured when a request is accepted, so changes to them during the walk have no effect on it.

Top module: `tt_walker`

## Requirements
- R1: After reset, busy, done and memReqValid are all 0.
- R2: With N = splitN, a virtual address at or below 0xFFFFFFFF >> N uses baseLo masked by 0xFFFFFFFF << (14 − N); any higher address uses baseHi masked by 0xFFFFFFFF << 14. The first read address is that masked base ORed with (va & 0xFFF00000 & bound) >> 18, where bound is 0xFFFFFFFF >> N for baseLo and 0xFFFFFFFF for baseHi.
- R3: A first-level descriptor with bits [1:0] = 00 ends the walk with fault = 1 after exactly one read.
- R4: A first-level descriptor with bit 1 = 1 and bit 18 = 0 ends the walk after one read, with PA = {desc[31:20], va[19:0]}.
- R5: A first-level descriptor with bit 1 = 1 and bit 18 = 1 ends the walk after one read. It faults if any bit of desc & 0x00F001E0 is set; otherwise PA = {desc[31:24], va[23:0]}.
- R6: A first-level descriptor with bits [1:0] = 01 causes a second read at address {desc[31:10], va[19:12], 2'b00}.
- R7: A second-level descriptor with bits [1:0] = 00 faults; 01 gives PA = {desc[31:16], va[15:0]}; 10 or 11 gives PA = {desc[31:12], va[11:0]}.
- R8: memReqValid stays high with memAddr unchanged until memReqReady is seen. No new read is issued before the previous response arrives. memReqValid is high only while busy.
- R9: busy rises in the cycle after a request is accepted and stays high through the done cycle. done lasts one cycle and is followed by busy = 0. Requests seen while busy start no walk.
- R10: Changes to reqVa, splitN, baseLo or baseHi after acceptance do not change the running walk's read addresses or result.
- R11: When fault is 1 in the done cycle, paOut is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request, taken when not busy |
| reqVa | input | 32 | Virtual address to translate |
| splitN | input | 3 | Range split value N |
| baseLo | input | 32 | Table base used for the low address range |
| baseHi | input | 32 | Table base used for the high address range |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| paOut | output | 32 | Physical address, valid with done |
| fault | output | 1 | Translation fault, valid with done |
| memReqValid | output | 1 | Descriptor read request |
| memReqReady | input | 1 | Memory accepts the read request |
| memAddr | output | 32 | Byte address of the descriptor word |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 32 | Descriptor word read |

## Verification
The hardest situation to create from the ports is a walk whose inputs change while it runs. This has to happen while the port is stalled, a response is still pending and a second request is already arriving. The stimulus creates it in every walk. Right after acceptance, the bench overwrites the split value, both bases and the address with random values and holds reqValid high until the done pulse. Meanwhile the memory model stalls readiness at random and delays each response by one to three cycles. Directed cases cover the split boundary at N = 7 on both sides, N = 0, and supersections with and without high address bits.

// File: rtl/tt_walker_pkg.sv
`timescale 1ns/1ps
package tt_walker_pkg;
  localparam int ADDR_W  = 32;
  localparam int SPLIT_W = 3;
  localparam int L1_ALIGN = 14;   // table alignment with no split
  localparam int L1_IDX_SHIFT = 18;

  typedef enum logic [2:0] {
    ST_IDLE, ST_L1REQ, ST_L1WAIT, ST_L2REQ, ST_L2WAIT, ST_FIN
  } walkState_t;

  typedef struct packed {
    logic load;    // capture request and first read address
    logic takeL1;  // consume first-level descriptor
    logic takeL2;  // consume second-level descriptor
  } walkStrobe_t;
endpackage

// File: rtl/tt_walker_ctrl.sv
`timescale 1ns/1ps
module tt_walker_ctrl
  import tt_walker_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        memReqReady,
  input  logic        memRspValid,
  input  logic        l1Terminal,
  output walkStrobe_t strobe,
  output logic        busy,
  output logic        done,
  output logic        memReqValid
);
  walkState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:   if (reqValid) stateNext = ST_L1REQ;
      ST_L1REQ:  if (memReqReady) stateNext = ST_L1WAIT;
      ST_L1WAIT: if (memRspValid) stateNext = l1Terminal ? ST_FIN : ST_L2REQ;
      ST_L2REQ:  if (memReqReady) stateNext = ST_L2WAIT;
      ST_L2WAIT: if (memRspValid) stateNext = ST_FIN;
      ST_FIN:    stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    strobe.load   = (state == ST_IDLE) && reqValid;
    strobe.takeL1 = (state == ST_L1WAIT) && memRspValid;
    strobe.takeL2 = (state == ST_L2WAIT) && memRspValid;
  end

  assign busy        = (state != ST_IDLE);
  assign done        = (state == ST_FIN);
  assign memReqValid = (state == ST_L1REQ) || (state == ST_L2REQ);
endmodule

// File: rtl/tt_walker_dp.sv
`timescale 1ns/1ps
module tt_walker_dp
  import tt_walker_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  walkStrobe_t        strobe,
  input  logic [ADDR_W-1:0]  reqVa,
  input  logic [SPLIT_W-1:0] splitN,
  input  logic [ADDR_W-1:0]  baseLo,
  input  logic [ADDR_W-1:0]  baseHi,
  input  logic [ADDR_W-1:0]  memRspData,
  output logic               l1Terminal,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [ADDR_W-1:0]  paOut,
  output logic               fault
);
  localparam logic [ADDR_W-1:0] ALL_ONES = '1;
  localparam logic [ADDR_W-1:0] SECT_MASK = 32'hFFF0_0000;
  localparam logic [ADDR_W-1:0] SUPER_HI_BITS = 32'h00F0_01E0;

  logic [ADDR_W-1:0] vaQ, addrQ, paQ;
  logic              faultQ;

  // first read address from the live request inputs
  logic [ADDR_W-1:0] loBound, selBound, selMask, selBase, l1Addr;
  logic              useHi;
  always_comb begin
    loBound  = ALL_ONES >> splitN;
    useHi    = reqVa > loBound;
    selBound = useHi ? ALL_ONES : loBound;
    selMask  = useHi ? (ALL_ONES << L1_ALIGN)
                     : (ALL_ONES << (L1_ALIGN - int'(splitN)));
    selBase  = useHi ? baseHi : baseLo;
    l1Addr   = (selBase & selMask) |
               ((reqVa & (SECT_MASK & selBound)) >> L1_IDX_SHIFT);
  end

  // first-level descriptor decode
  logic              l1Invalid, l1Super, l1Fault;
  logic [ADDR_W-1:0] l1Pa, l2Addr;
  always_comb begin
    l1Invalid  = (memRspData & 32'h3) == 32'h0;
    l1Super    = (memRspData & 32'h0004_0002) == 32'h0004_0002;
    l1Terminal = l1Invalid || ((memRspData & 32'h2) != 32'h0);
    l1Fault    = l1Invalid || (l1Super && ((memRspData & SUPER_HI_BITS) != 32'h0));
    if (l1Fault)
      l1Pa = '0;
    else if (l1Super)
      l1Pa = (memRspData & 32'hFF00_0000) | (vaQ & 32'h00FF_FFFF);
    else
      l1Pa = (memRspData & SECT_MASK) | (vaQ & 32'h000F_FFFF);
    l2Addr = (memRspData & 32'hFFFF_FC00) | ((vaQ & 32'h000F_F000) >> 10);
  end

  // second-level descriptor decode
  logic              l2Fault;
  logic [ADDR_W-1:0] l2Pa;
  always_comb begin
    l2Fault = (memRspData & 32'h3) == 32'h0;
    if (l2Fault)
      l2Pa = '0;
    else if ((memRspData & 32'h3) == 32'h1)
      l2Pa = (memRspData & 32'hFFFF_0000) | (vaQ & 32'h0000_FFFF);
    else
      l2Pa = (memRspData & 32'hFFFF_F000) | (vaQ & 32'h0000_0FFF);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaQ    <= '0;
      addrQ  <= '0;
      paQ    <= '0;
      faultQ <= 1'b0;
    end else begin
      if (strobe.load) begin
        vaQ   <= reqVa;
        addrQ <= l1Addr;
      end
      if (strobe.takeL1) begin
        if (l1Terminal) begin
          paQ    <= l1Pa;
          faultQ <= l1Fault;
        end else begin
          addrQ  <= l2Addr;
        end
      end
      if (strobe.takeL2) begin
        paQ    <= l2Pa;
        faultQ <= l2Fault;
      end
    end
  end

  assign memAddr = addrQ;
  assign paOut   = paQ;
  assign fault   = faultQ;
endmodule

// File: rtl/tt_walker.sv
`timescale 1ns/1ps
module tt_walker
  import tt_walker_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [31:0] reqVa,
  input  logic [2:0]  splitN,
  input  logic [31:0] baseLo,
  input  logic [31:0] baseHi,
  output logic        busy,
  output logic        done,
  output logic [31:0] paOut,
  output logic        fault,
  output logic        memReqValid,
  input  logic        memReqReady,
  output logic [31:0] memAddr,
  input  logic        memRspValid,
  input  logic [31:0] memRspData
);
  walkStrobe_t strobe;
  logic        l1Terminal;

  tt_walker_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .memReqReady(memReqReady), .memRspValid(memRspValid),
    .l1Terminal(l1Terminal), .strobe(strobe),
    .busy(busy), .done(done), .memReqValid(memReqValid)
  );

  tt_walker_dp uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqVa(reqVa), .splitN(splitN), .baseLo(baseLo), .baseHi(baseHi),
    .memRspData(memRspData), .l1Terminal(l1Terminal),
    .memAddr(memAddr), .paOut(paOut), .fault(fault)
  );
endmodule

// File: rtl/tt_walker_chk.sv
`timescale 1ns/1ps
module tt_walker_chk (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        busy,
  input logic        done,
  input logic [31:0] paOut,
  input logic        fault,
  input logic        memReqValid,
  input logic        memReqReady,
  input logic [31:0] memAddr
);
  assert_accept_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !busy |=> busy);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done && !busy);

  assert_done_in_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memAddr));

  assert_req_when_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> busy && !done);

  assert_fault_zero_pa_R11: assert property (@(posedge clk) disable iff (!rstN)
    done && fault |-> paOut == 32'h0);
endmodule

bind tt_walker tt_walker_chk uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .busy(busy), .done(done),
  .paOut(paOut), .fault(fault), .memReqValid(memReqValid),
  .memReqReady(memReqReady), .memAddr(memAddr)
);

// File: tb/tb_tt_walker.sv
`timescale 1ns/1ps
module tb_tt_walker;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqVa = '0;
  logic [2:0]  splitN = '0;
  logic [31:0] baseLo = '0, baseHi = '0;
  logic        busy, done, fault, memReqValid;
  logic [31:0] paOut, memAddr;
  logic        memReqReady = 1'b0, memRspValid = 1'b0;
  logic [31:0] memRspData = '0;

  always #4 clk = ~clk;  // 125 MHz

  tt_walker dut (.*);

  int errors = 0, checks = 0;
  bit finished = 0;

  // memory model state
  logic [31:0] d1, d2, a1Seen, a2Seen;
  int reads = 0, rspCnt = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory responder
  initial begin
    forever begin
      @(negedge clk);
      memRspValid = 1'b0;
      if (rspCnt > 0) begin
        rspCnt--;
        if (rspCnt == 0) begin
          memRspValid = 1'b1;
          memRspData  = (reads == 1) ? d1 : d2;
        end
      end
      memReqReady = ($urandom % 3) != 0;
      if (memReqValid && memReqReady) begin
        reads++;
        if (reads == 1) a1Seen = memAddr; else a2Seen = memAddr;
        rspCnt = 1 + ($urandom % 3);
      end
    end
  end

  function automatic void refWalk(input logic [31:0] va, input logic [2:0] n,
      input logic [31:0] b0, input logic [31:0] b1, input logic [31:0] e1,
      input logic [31:0] e2, output logic [31:0] pa, output logic flt,
      output int nr, output logic [31:0] a1, output logic [31:0] a2);
    logic [31:0] bound0, base, mask, rng;
    bound0 = 32'hFFFFFFFF >> n;
    if (va > bound0) begin base = b1; mask = 32'hFFFFFFFF << 14; rng = 32'hFFFFFFFF; end
    else begin base = b0; mask = 32'hFFFFFFFF << (14 - int'(n)); rng = bound0; end
    a1 = (base & mask) | ((va & (32'hFFF00000 & rng)) >> 18);
    a2 = '0; nr = 1; pa = '0; flt = 1'b0;
    if (e1[1:0] == 2'b00) flt = 1'b1;
    else if (e1[1] && !e1[18]) pa = {e1[31:20], va[19:0]};
    else if (e1[1]) begin
      if ((e1 & 32'h00F001E0) != 0) flt = 1'b1;
      else pa = {e1[31:24], va[23:0]};
    end else begin
      nr = 2;
      a2 = {e1[31:10], va[19:12], 2'b00};
      if (e2[1:0] == 2'b00) flt = 1'b1;
      else if (e2[1:0] == 2'b01) pa = {e2[31:16], va[15:0]};
      else pa = {e2[31:12], va[11:0]};
    end
  endfunction

  task automatic runWalk(input logic [31:0] va, input logic [2:0] n,
      input logic [31:0] b0, input logic [31:0] b1, input logic [31:0] e1,
      input logic [31:0] e2, input string tag);
    logic [31:0] expPa, expA1, expA2;
    logic expFlt;
    int expNr;
    int waitCnt;
    refWalk(va, n, b0, b1, e1, e2, expPa, expFlt, expNr, expA1, expA2);
    d1 = e1; d2 = e2;
    @(negedge clk);
    reads = 0;
    reqValid = 1'b1; reqVa = va; splitN = n; baseLo = b0; baseHi = b1;
    @(negedge clk);
    check(busy == 1'b1, {"R9 busy after accept ", tag}, {31'b0, busy}, 32'h1);
    // R10: scramble inputs and keep requesting during the walk
    reqVa = $urandom; splitN = 3'($urandom); baseLo = $urandom; baseHi = $urandom;
    waitCnt = 0;
    while (!done && waitCnt < 60) begin
      @(negedge clk);
      waitCnt++;
    end
    reqValid = 1'b0;
    check(done == 1'b1, {"R9 done seen ", tag}, {31'b0, done}, 32'h1);
    check(fault == expFlt, {"R3/R5/R7 fault R10 ", tag}, {31'b0, fault}, {31'b0, expFlt});
    check(paOut == expPa, {"R4/R5/R7 pa R10 R11 ", tag}, paOut, expPa);
    check(reads == expNr, {"R3 R4 R6 R8 read count ", tag}, reads, expNr);
    check(a1Seen == expA1, {"R2 first address ", tag}, a1Seen, expA1);
    if (expNr == 2)
      check(a2Seen == expA2, {"R6 second address ", tag}, a2Seen, expA2);
    @(negedge clk);
    check(!done && !busy, {"R9 pulse end, ignored request ", tag},
          {30'b0, done, busy}, 32'h0);
    check(reads == expNr, {"R9 no extra walk ", tag}, reads, expNr);
  endtask

  function automatic logic [31:0] randDesc1(input int kind);
    logic [31:0] d;
    d = $urandom;
    case (kind)
      0: d = d & ~32'h3;                                  // invalid
      1: d = (d & ~32'h0004_0000) | 32'h2;                // section
      2: d = (d & ~32'h00F0_01E0) | 32'h0004_0002;        // super ok
      3: d = d | 32'h0004_0002;                           // super random
      default: d = (d & ~32'h3) | 32'h1;                  // table
    endcase
    return d;
  endfunction

  initial begin
    process::self().srandom(32'h5EED_1234);
    repeat (3) @(negedge clk);
    check(!busy && !done && !memReqValid, "R1 reset state",
          {29'b0, busy, done, memReqValid}, 32'h0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done && !memReqValid, "R1 idle after reset",
          {29'b0, busy, done, memReqValid}, 32'h0);

    // directed corners
    runWalk(32'h1234_5678, 3'd0, 32'h8000_4000, 32'h9000_0000, 32'hABC0_0C02, 0, "R4 section N0");
    runWalk(32'hFFFF_FFFF, 3'd0, 32'h8000_4000, 32'h9000_0000, 32'h5600_0002 | 32'h0004_0000, 0, "R5 super ok");
    runWalk(32'h0012_3456, 3'd1, 32'h8000_2000, 32'h9000_0000, 32'h5610_0000 | 32'h0004_0002, 0, "R5 super high bits");
    runWalk(32'h0012_3456, 3'd2, 32'h8000_1000, 32'h9000_0000, 32'hDEAD_BEE0, 0, "R3 invalid L1");
    runWalk(32'h01FF_FFFF, 3'd7, 32'hFFFF_FFFF, 32'hAAAA_AAAA, 32'h3000_0002, 0, "R2 N7 low side");
    runWalk(32'h0200_0000, 3'd7, 32'hFFFF_FFFF, 32'hAAAA_AAAA, 32'h3000_0002, 0, "R2 N7 high side");
    runWalk(32'h0ABC_DEF0, 3'd0, 32'h8000_0000, 32'h0, 32'h1234_5401, 32'hCAFE_0001, "R7 large page");
    runWalk(32'h0ABC_DEF0, 3'd0, 32'h8000_0000, 32'h0, 32'h1234_5401, 32'hCAFE_B002, "R7 small page");
    runWalk(32'h0ABC_DEF0, 3'd0, 32'h8000_0000, 32'h0, 32'h1234_5401, 32'hCAFE_B00C, "R7 invalid L2");

    // random walks
    for (int i = 0; i < 400; i++) begin
      logic [31:0] rv, rb0, rb1, rd2;
      logic [2:0] rn;
      rv = $urandom; rn = 3'($urandom); rb0 = $urandom; rb1 = $urandom; rd2 = $urandom;
      if (i % 4 == 0) rv = rv >> (1 + ($urandom % 8));
      runWalk(rv, rn, rb0, rb1, randDesc1($urandom % 6), rd2, "random");
    end

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule